// File: doc/BRIEF.md
# Two-Mode Page Table Walker

This block translates a virtual address into a physical address by reading a tree of page tables from memory, one entry per level. A caller presents a virtual address, a mode select and the frame number of the root table. The walker then issues single 64-bit entry reads, one at a time, on a valid/ready request port. Each response either gives the base of the next table or ends the walk.

Two modes share one datapath. The 64-bit mode walks four levels that cover 48 virtual address bits. Before any memory access, it rejects an address whose upper bits are not a sign extension of bit 47. The 32-bit extended mode walks three levels: a small top level indexed by two bits, then two full 9-bit levels. It yields a 36-bit physical address.

Each walk ends with a one-cycle done pulse. The pulse carries either a physical address or a fault code with the level at which the walk stopped.

Top module: `page_walker`

## Requirements
- R1: `req_ready_o` is high only while the walker is idle. A request is accepted on a cycle with `req_valid_i` and `req_ready_o` both high. A request presented while a walk is in progress has no effect on that walk's reads or result.
- R2: In 64-bit mode (`req_mode_i`=1) the walk reads four levels, numbered 0 to 3. Their 9-bit indices are virtual address bits 47:39, 38:30, 29:21 and 20:12, in that order.
- R3: In 32-bit mode (`req_mode_i`=0) the walk reads three levels. Level 0 is indexed by virtual address bits 31:30, zero-extended to 9 bits. Levels 1 and 2 are indexed by bits 29:21 and 20:12. Virtual address bits 63:32 are ignored.
- R4: Each read address is {table frame, index, 3'b000}, 52 bits wide. The frame for level 0 is `root_frame_i`; for every later level it is bits 51:12 of the previous entry.
- R5: In 64-bit mode, when bits 63:48 are not all equal to bit 47, the done pulse follows on the cycle after acceptance. It carries fault code 1 and `paddr_o`=0, and the walk issues no memory read.
- R6: Bit 0 of a fetched entry is the present flag. When it is clear, the walk stops with fault code 2, `fault_lvl_o` equal to that entry's level and `paddr_o`=0, and issues no further read.
- R7: On success the full address is {last entry bits 51:12, virtual address bits 11:0}. `paddr_o` takes its low 40 bits in 64-bit mode. In 32-bit mode it takes the low 36 bits, with bits 39:36 zero. The fault code is 0.
- R8: A memory request holds `mem_req_valid_o` and a stable address until `mem_req_ready_i`. Only one read is outstanding at a time, and a response may arrive any number of cycles later.
- R9: `done_o` is high for exactly one cycle per accepted request, and the walker is idle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 64 | Virtual address |
| req_mode_i | input | 1 | 1: four-level 48-bit mode, 0: three-level 32-bit mode |
| root_frame_i | input | 40 | Frame number of the top-level table |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 52 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Fetched table entry |
| done_o | output | 1 | One-cycle completion pulse |
| fault_code_o | output | 2 | 0 success, 1 non-canonical, 2 entry not present |
| fault_lvl_o | output | 2 | Level of the entry that was not present |
| paddr_o | output | 40 | Physical address |

## Verification
The bench builds the walker with its default parameters: 64-bit virtual addresses, 9-bit indices, 12-bit offset and a 40-bit physical width. These defaults bring the 36-bit truncation of the 32-bit mode and the 40-bit truncation of the 64-bit mode within reach, because the bench's memory model returns frames with bits set above both limits. The model also places junk in the entry's unused bits. Randomized ready and response delays exercise request holding and arbitrary latency. A clear present bit is placed at every level of both modes, and the canonical boundary addresses on both sides of the hole are driven directly.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NONCANON = 2'd1,
    FLT_ABSENT   = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_DONE
  } st_e;
endpackage

// File: rtl/pw_index.sv
// Per-level table index selection for both walk modes.
module pw_index #(
  parameter int VPN_W  = 36,
  parameter int IDX_W  = 9,
  parameter int NL64   = 4,
  parameter int NL32   = 3,
  parameter int VA32_W = 32,
  parameter int OFF_W  = 12,
  localparam int LVL_W = $clog2(NL64),
  localparam int TOP_W = VA32_W - OFF_W - (NL32 - 1) * IDX_W
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             mode64_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx64 [NL64];
  logic [IDX_W-1:0] idx32 [NL64];

  for (genvar l = 0; l < NL64; l++) begin : g_l64
    assign idx64[l] = vpn_i[(NL64-1-l)*IDX_W +: IDX_W];
  end

  for (genvar l = 0; l < NL64; l++) begin : g_l32
    if (l == 0) begin : g_top
      assign idx32[l] = {{(IDX_W-TOP_W){1'b0}}, vpn_i[VA32_W-OFF_W-1 -: TOP_W]};
    end else if (l < NL32) begin : g_full
      assign idx32[l] = vpn_i[(NL32-1-l)*IDX_W +: IDX_W];
    end else begin : g_none
      assign idx32[l] = '0;
    end
  end

  assign idx_o = mode64_i ? idx64[lvl_i] : idx32[lvl_i];
endmodule

// File: rtl/pw_canon.sv
// Upper address bits must replicate the top translated bit.
module pw_canon #(
  parameter int VA_W  = 64,
  parameter int USE_W = 48
) (
  input  logic [VA_W-1:0] va_i,
  output logic            ok_o
);
  logic [VA_W-USE_W:0] ext;
  logic                unused_lo;
  assign ext       = va_i[VA_W-1:USE_W-1];
  assign unused_lo = ^va_i[USE_W-2:0];
  assign ok_o      = (&ext) | ~(|ext);
endmodule

// File: rtl/pw_frame.sv
// Final physical address formation with mode-dependent width.
module pw_frame #(
  parameter int FRM_W  = 40,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 40,
  parameter int PA32_W = 36
) (
  input  logic [FRM_W-1:0] frm_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             mode64_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [FRM_W+OFF_W-1:0] full;
  logic                   unused_hi;
  assign full      = {frm_i, off_i};
  assign unused_hi = ^full[FRM_W+OFF_W-1:PA_W];
  assign pa_o      = mode64_i ? full[PA_W-1:0]
                              : {{(PA_W-PA32_W){1'b0}}, full[PA32_W-1:0]};
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int ENT_W  = 64,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int NL64   = 4,
  parameter int NL32   = 3,
  parameter int VA32_W = 32,
  parameter int FRM_HI = 51,
  parameter int PA_W   = 40,
  parameter int PA32_W = 36,
  localparam int USE_W = OFF_W + NL64 * IDX_W,
  localparam int FRM_W = FRM_HI - OFF_W + 1,
  localparam int MA_W  = FRM_HI + 1,
  localparam int LVL_W = $clog2(NL64),
  localparam int SH_W  = OFF_W - IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_mode_i,
  input  logic [FRM_W-1:0] root_frame_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [MA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [ENT_W-1:0] mem_rsp_data_i,
  output logic             done_o,
  output logic [1:0]       fault_code_o,
  output logic [LVL_W-1:0] fault_lvl_o,
  output logic [PA_W-1:0]  paddr_o
);
  st_e              state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [USE_W-1:0] va_q;
  logic             mode_q;
  logic [FRM_W-1:0] base_q;
  logic [PA_W-1:0]  pa_q;
  flt_e             flt_q;
  logic [LVL_W-1:0] flvl_q;

  logic             canon_ok;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  pa_new;
  logic [LVL_W-1:0] last_lvl;
  logic             present;
  logic             unused_ent;

  pw_canon #(.VA_W(VA_W), .USE_W(USE_W)) u_canon (
    .va_i (req_vaddr_i),
    .ok_o (canon_ok)
  );

  pw_index #(
    .VPN_W(USE_W-OFF_W), .IDX_W(IDX_W), .NL64(NL64), .NL32(NL32),
    .VA32_W(VA32_W), .OFF_W(OFF_W)
  ) u_index (
    .vpn_i    (va_q[USE_W-1:OFF_W]),
    .mode64_i (mode_q),
    .lvl_i    (lvl_q),
    .idx_o    (idx)
  );

  pw_frame #(.FRM_W(FRM_W), .OFF_W(OFF_W), .PA_W(PA_W), .PA32_W(PA32_W)) u_frame (
    .frm_i    (mem_rsp_data_i[FRM_HI:OFF_W]),
    .off_i    (va_q[OFF_W-1:0]),
    .mode64_i (mode_q),
    .pa_o     (pa_new)
  );

  assign present    = mem_rsp_data_i[0];
  assign unused_ent = ^{mem_rsp_data_i[ENT_W-1:MA_W], mem_rsp_data_i[OFF_W-1:1]};
  assign last_lvl   = mode_q ? LVL_W'(NL64-1) : LVL_W'(NL32-1);

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_RD);
  assign mem_req_addr_o  = {base_q, idx, {SH_W{1'b0}}};
  assign done_o          = (state_q == ST_DONE);
  assign fault_code_o    = flt_q;
  assign fault_lvl_o     = flvl_q;
  assign paddr_o         = pa_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      mode_q  <= 1'b0;
      base_q  <= '0;
      pa_q    <= '0;
      flt_q   <= FLT_NONE;
      flvl_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i[USE_W-1:0];
          mode_q <= req_mode_i;
          base_q <= root_frame_i;
          lvl_q  <= '0;
          if (req_mode_i && !canon_ok) begin
            flt_q   <= FLT_NONCANON;
            flvl_q  <= '0;
            pa_q    <= '0;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!present) begin
            flt_q   <= FLT_ABSENT;
            flvl_q  <= lvl_q;
            pa_q    <= '0;
            state_q <= ST_DONE;
          end else if (lvl_q == last_lvl) begin
            flt_q   <= FLT_NONE;
            flvl_q  <= '0;
            pa_q    <= pa_new;
            state_q <= ST_DONE;
          end else begin
            base_q  <= mem_rsp_data_i[FRM_HI:OFF_W];
            lvl_q   <= lvl_q + 1'b1;
            state_q <= ST_RD;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  assert_noncanon_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_mode_i &&
     !((&req_vaddr_i[VA_W-1:USE_W-1]) || !(|req_vaddr_i[VA_W-1:USE_W-1])))
    |=> (done_o && fault_code_o == FLT_NONCANON));

  assert_absent_lvl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == FLT_ABSENT) |-> (fault_lvl_o <= last_lvl));

  assert_offset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == FLT_NONE) |-> (paddr_o[OFF_W-1:0] == va_q[OFF_W-1:0]));

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        req_mode = 1'b0;
  logic [39:0] root_frame = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [1:0]  fault_code;
  logic [1:0]  fault_lvl;
  logic [39:0] paddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  page_walker u_page_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_mode_i(req_mode), .root_frame_i(root_frame),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .done_o(done), .fault_code_o(fault_code), .fault_lvl_o(fault_lvl), .paddr_o(paddr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] frm_of(input logic [51:0] a);
    logic [63:0] m;
    m = {12'h0, a} * 64'h9E37_79B9_7F4A_7C15;
    return m[63:24];
  endfunction

  // Entry model: junk in unused fields, frame from address hash.
  function automatic logic [63:0] ent_of(input logic [51:0] a, input bit pres);
    return {12'hA5C, frm_of(a), 11'h3F1, pres};
  endfunction

  function automatic logic [8:0] idx_of(input logic [63:0] va, input bit m64, input int l);
    if (m64) return va[12 + (3-l)*9 +: 9];
    if (l == 0) return {7'b0, va[31:30]};
    return va[12 + (2-l)*9 +: 9];
  endfunction

  function automatic bit canon(input logic [63:0] va);
    return (&va[63:47]) || !(|va[63:47]);
  endfunction

  task automatic walk(input logic [63:0] va, input bit m64, input logic [39:0] root,
                      input int fail_lvl, input bit poke);
    logic [51:0] ea [4];
    logic [39:0] base;
    logic [51:0] full;
    logic [39:0] exp_pa;
    logic [1:0]  exp_code;
    logic [1:0]  exp_lvl;
    int nl, nreads, reads, cyc;
    nl = m64 ? 4 : 3;
    base = root;
    exp_code = 2'd0; exp_lvl = 2'd0; exp_pa = '0; nreads = 0;
    for (int l = 0; l < 4; l++) ea[l] = '0;
    if (m64 && !canon(va)) begin
      exp_code = 2'd1;
    end else begin
      for (int l = 0; l < nl; l++) begin
        ea[l] = {base, idx_of(va, m64, l), 3'b000};
        nreads = l + 1;
        if (l == fail_lvl) begin
          exp_code = 2'd2; exp_lvl = 2'(l);
          break;
        end
        base = frm_of(ea[l]);
      end
      if (exp_code == 2'd0) begin
        full = {base, va[11:0]};
        exp_pa = m64 ? full[39:0] : {4'h0, full[35:0]};
      end
    end

    chk(req_ready == 1'b1, "R1 idle ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_mode = m64; root_frame = root;
    @(negedge clk);
    if (poke) begin
      req_vaddr = ~va; req_mode = ~m64; root_frame = ~root;
    end else begin
      req_valid = 1'b0;
    end
    reads = 0; cyc = 0;
    while (!done && cyc < 400) begin
      if (mem_req_valid) begin
        chk(reads < nreads && mem_req_addr == ea[reads & 3], "R2/R3/R4 entry address",
            64'(mem_req_addr), 64'(ea[reads & 3]));
        if (poke) chk(req_ready == 1'b0, "R1 busy not ready", 64'(req_ready), 64'd0);
        repeat ($urandom % 3) @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ea[reads & 3], "R8 request held until ready",
            64'(mem_req_addr), 64'(ea[reads & 3]));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid == 1'b0, "R8 one read outstanding", 64'(mem_req_valid), 64'd0);
        repeat ($urandom % 4) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = ent_of(ea[reads & 3], reads != fail_lvl);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = {$urandom, $urandom};
        reads++;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R9 done reached", 64'(done), 64'd1);
    chk(reads == nreads, exp_code == 2'd1 ? "R5 read count" : "R6 read count",
        64'(reads), 64'(nreads));
    chk(fault_code == exp_code, "R5/R6/R7 fault code", 64'(fault_code), 64'(exp_code));
    if (exp_code == 2'd2)
      chk(fault_lvl == exp_lvl, "R6 fault level", 64'(fault_lvl), 64'(exp_lvl));
    chk(paddr == exp_pa, m64 ? "R7 paddr 64-bit" : "R7 paddr 32-bit", 64'(paddr), 64'(exp_pa));
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R9 single pulse then idle", {62'd0, done, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] va;
    bit m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R1/R9 reset state",
        {61'd0, req_ready, done, mem_req_valid}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);

    // canonical boundaries
    walk(64'h0000_7FFF_FFFF_FFFF, 1'b1, 40'h12_3456_789A, 9, 1'b0);
    walk(64'hFFFF_8000_0000_0ABC, 1'b1, 40'hFF_FFFF_FFFF, 9, 1'b0);
    walk(64'h0000_8000_0000_0000, 1'b1, 40'h1, 9, 1'b0);
    walk(64'hFFFF_7FFF_FFFF_FFFF, 1'b1, 40'h1, 9, 1'b0);
    walk(64'h0001_0000_0000_0000, 1'b1, 40'h1, 9, 1'b0);
    // 32-bit mode ignores upper bits; top level index from bits 31:30
    walk(64'hDEAD_BEEF_C000_0123, 1'b0, 40'hAB_CDEF_0123, 9, 1'b0);
    walk(64'h0000_0000_7FFF_FFFF, 1'b0, 40'h00_0000_0000, 9, 1'b0);
    // absent entry at every level
    for (int l = 0; l < 4; l++) walk(64'h0000_1234_5678_9ABC, 1'b1, 40'h55_5555_5555, l, 1'b0);
    for (int l = 0; l < 3; l++) walk(64'h0000_0000_8765_4321, 1'b0, 40'h0A_0A0A_0A0A, l, 1'b0);
    // requests while busy
    walk(64'hFFFF_FFFF_FFFF_F000, 1'b1, 40'h33_3333_3333, 9, 1'b1);
    walk(64'h0000_0000_4444_4444, 1'b0, 40'h77_7777_7777, 1, 1'b1);

    for (int n = 0; n < 80; n++) begin
      va = {$urandom, $urandom};
      m = 1'($urandom % 2);
      if (m && ($urandom % 5 != 0)) va[63:48] = {16{va[47]}};
      walk(va, m, {$urandom % 256, $urandom}, $urandom % 6, 1'($urandom % 4 == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule